// File: doc/BRIEF.md
# Low-Power Escape Entry Transmitter

This block drives the two single-ended wires of a serial data lane while the lane runs at low power. From the idle stop level it walks the lane through the escape entry ladder, then sends an eight-bit command that picks one of three follow-ups. The first streams low-power data bytes, and the lane may pause between them. The second parks the lane in an ultra-low-power state until a wake request arrives. The third sends a reset trigger with no payload. Each follow-up ends with a short exit pulse that returns the lane to stop.

The caller pulses `start` with a mode code. For data mode it offers bytes on a valid/ready pair and flags the final byte. For the parked state it raises `wakeReq` when the lane should come back, and it sets `wakeTime` to how long the wake level is held. Every line level, except the parked, waiting and wake levels, lasts `LPX_CYCLES` clock cycles.

Top module: `lpEscTx`

## Requirements
- R1: After reset, and while reset is held, the line is LP-11 ({lineP,lineN} = 2'b11), and `busy`, `ulpsActive`, `txReady` and `rstTrigger` are low.
- R2: A `start` sampled in stop with mode 0, 1 or 2 puts LP-10 on the line in the next cycle. The sequence LP-10, LP-00, LP-01, LP-00 follows, each level held for LPX_CYCLES cycles.
- R3: A `start` with mode 3 is ignored: the line stays LP-11 and `busy` stays low. A `start` during a transfer does not change that transfer.
- R4: The command byte is sent LSB first, right after the entry sequence. Mode 0 (low-power data) sends 8'h87 (bit order on the wire 11100001). Mode 1 (ultra-low-power) sends 8'h78 (00011110). Mode 2 (reset trigger) sends 8'h46 (01100010).
- R5: Each bit drives LP-10 for a 1 or LP-01 for a 0 for LPX_CYCLES cycles. LP-00 follows for LPX_CYCLES cycles.
- R6: In data mode, `txReady` is high, and the line holds LP-00, while the block waits for a byte. A byte is taken in a cycle with `txValid` and `txReady` both high and is sent LSB first. The wait may last any number of cycles.
- R7: After the space of the last bit of a byte taken with `txLast` high, the line shows LP-10 for LPX_CYCLES cycles and then LP-11.
- R8: In ultra-low-power mode, after the command the line holds LP-00 and `ulpsActive` is high until `wakeReq` is sampled high.
- R9: After the wake request, the line shows LP-10 for `wakeTime` cycles (a value of 0 counts as 1) and then LP-11.
- R10: In reset-trigger mode, the command's last space is followed directly by LP-10 for LPX_CYCLES cycles and then LP-11. `rstTrigger` is high for exactly the last LP-10 cycle.
- R11: `busy` is high from the cycle after an accepted `start` until the line returns to LP-11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an escape sequence (taken only in stop) |
| mode | input | 2 | 0 data, 1 ultra-low-power, 2 reset trigger, 3 reserved |
| txData | input | 8 | Data byte to send |
| txValid | input | 1 | txData is offered |
| txLast | input | 1 | The offered byte is the final one |
| txReady | output | 1 | Block waits for a data byte |
| wakeReq | input | 1 | Leave the ultra-low-power state |
| wakeTime | input | WAKE_W | Wake level length in cycles |
| lineP | output | 1 | Positive line level |
| lineN | output | 1 | Negative line level |
| busy | output | 1 | A sequence is in progress |
| ulpsActive | output | 1 | Lane parked in the ultra-low-power state |
| rstTrigger | output | 1 | Pulse in the final cycle of a reset-trigger exit |

## Verification
The bench builds the block with LPX_CYCLES = 2 and WAKE_W = 4. The short level time keeps every run of bits short enough to compare cycle for cycle. The narrow wake field reaches both ends of `wakeTime`: 0, which is forced up to one cycle, and 15, the full-scale value. These values also make room for long data pauses next to zero-length ones, a wake request in the first parked cycle, and a reset that lands in the middle of a parked lane.

// File: rtl/lpEscPkg.sv
`timescale 1ns/1ps
package lpEscPkg;

  typedef enum logic [1:0] {
    MODE_LPDT  = 2'd0,
    MODE_ULPS  = 2'd1,
    MODE_RESET = 2'd2,
    MODE_RSVD  = 2'd3
  } escMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTimer;
    logic useWake;
    logic loadCmd;
    logic loadData;
    logic shiftBit;
  } dpCtrl_t;

  localparam int CMD_W = 8;

  localparam logic [1:0] LINE_STOP  = 2'b11;
  localparam logic [1:0] LINE_HIGHP = 2'b10;
  localparam logic [1:0] LINE_HIGHN = 2'b01;
  localparam logic [1:0] LINE_SPACE = 2'b00;

  // command byte, shifted out LSB first
  function automatic logic [CMD_W-1:0] cmdCode(input escMode_t m);
    case (m)
      MODE_LPDT:  cmdCode = 8'h87;
      MODE_ULPS:  cmdCode = 8'h78;
      MODE_RESET: cmdCode = 8'h46;
      default:    cmdCode = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/lpEscDatapath.sv
`timescale 1ns/1ps
module lpEscDatapath
  import lpEscPkg::*;
#(
  parameter int LPX_CYCLES = 4,
  parameter int WAKE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  escMode_t          cmdMode,
  input  logic [CMD_W-1:0]  dataIn,
  input  logic [WAKE_W-1:0] wakeTime,
  output logic              timerDone,
  output logic              curBit,
  output logic              lastBit
);
  localparam int LPX_W = $clog2(LPX_CYCLES + 1);
  localparam int TMR_W = (LPX_W > WAKE_W) ? LPX_W : WAKE_W;
  localparam int CNT_W = $clog2(CMD_W);

  logic [TMR_W-1:0] tmrCnt;
  logic [TMR_W-1:0] tmrLen;
  logic [CMD_W-1:0] shReg;
  logic [CNT_W-1:0] bitCnt;

  // level duration: fixed LPX or programmable wake (0 counts as 1)
  always_comb begin
    if (ctl.useWake) begin
      tmrLen = TMR_W'(wakeTime);
      if (wakeTime == '0) tmrLen = TMR_W'(1);
    end else begin
      tmrLen = TMR_W'(LPX_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (ctl.loadTimer) begin
      tmrCnt <= tmrLen - TMR_W'(1);
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (ctl.loadCmd) begin
      shReg  <= cmdCode(cmdMode);
      bitCnt <= '0;
    end else if (ctl.loadData) begin
      shReg  <= dataIn;
      bitCnt <= '0;
    end else if (ctl.shiftBit) begin
      shReg  <= {1'b0, shReg[CMD_W-1:1]};
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign timerDone = (tmrCnt == '0);
  assign curBit    = shReg[0];
  assign lastBit   = (bitCnt == CNT_W'(CMD_W - 1));

  // control must never shift beyond the eighth bit
  assert_no_shift_past_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftBit |-> !lastBit);

endmodule

// File: rtl/lpEscCtrl.sv
`timescale 1ns/1ps
module lpEscCtrl
  import lpEscPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  escMode_t   modeIn,
  input  logic       txValid,
  input  logic       txLast,
  input  logic       wakeReq,
  input  logic       timerDone,
  input  logic       curBit,
  input  logic       lastBit,
  output dpCtrl_t    ctl,
  output logic [1:0] lineState,
  output logic       busy,
  output logic       ulpsActive,
  output logic       txReady,
  output logic       rstTrigger
);
  typedef enum logic [2:0] {
    S_STOP, S_ENTRY, S_MARK, S_SPACE, S_WAIT, S_ULPS, S_WAKE, S_EXIT
  } state_t;

  state_t   state, stateNx;
  logic [1:0] step, stepNx;
  escMode_t modeReg, modeNx;
  logic     inCmd, inCmdNx;
  logic     lastByte, lastByteNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_STOP;
      step     <= '0;
      modeReg  <= MODE_LPDT;
      inCmd    <= 1'b0;
      lastByte <= 1'b0;
    end else begin
      state    <= stateNx;
      step     <= stepNx;
      modeReg  <= modeNx;
      inCmd    <= inCmdNx;
      lastByte <= lastByteNx;
    end
  end

  always_comb begin
    stateNx    = state;
    stepNx     = step;
    modeNx     = modeReg;
    inCmdNx    = inCmd;
    lastByteNx = lastByte;
    ctl        = '0;
    case (state)
      S_STOP: begin
        if (start && modeIn != MODE_RSVD) begin
          stateNx       = S_ENTRY;
          stepNx        = '0;
          modeNx        = modeIn;
          inCmdNx       = 1'b1;
          ctl.loadTimer = 1'b1;
          ctl.loadCmd   = 1'b1;
        end
      end
      S_ENTRY: begin
        if (timerDone) begin
          ctl.loadTimer = 1'b1;
          if (step == 2'd3) stateNx = S_MARK;
          else              stepNx  = step + 2'd1;
        end
      end
      S_MARK: begin
        if (timerDone) begin
          stateNx       = S_SPACE;
          ctl.loadTimer = 1'b1;
        end
      end
      S_SPACE: begin
        if (timerDone) begin
          if (!lastBit) begin
            ctl.shiftBit  = 1'b1;
            ctl.loadTimer = 1'b1;
            stateNx       = S_MARK;
          end else if (inCmd) begin
            inCmdNx = 1'b0;
            case (modeReg)
              MODE_LPDT: stateNx = S_WAIT;
              MODE_ULPS: stateNx = S_ULPS;
              default: begin
                stateNx       = S_EXIT;
                ctl.loadTimer = 1'b1;
              end
            endcase
          end else if (lastByte) begin
            stateNx       = S_EXIT;
            ctl.loadTimer = 1'b1;
          end else begin
            stateNx = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (txValid) begin
          ctl.loadData  = 1'b1;
          ctl.loadTimer = 1'b1;
          lastByteNx    = txLast;
          stateNx       = S_MARK;
        end
      end
      S_ULPS: begin
        if (wakeReq) begin
          ctl.loadTimer = 1'b1;
          ctl.useWake   = 1'b1;
          stateNx       = S_WAKE;
        end
      end
      S_WAKE, S_EXIT: begin
        if (timerDone) stateNx = S_STOP;
      end
      default: stateNx = S_STOP;
    endcase
  end

  always_comb begin
    case (state)
      S_STOP:  lineState = LINE_STOP;
      S_ENTRY: begin
        case (step)
          2'd0:    lineState = LINE_HIGHP;
          2'd2:    lineState = LINE_HIGHN;
          default: lineState = LINE_SPACE;
        endcase
      end
      S_MARK:  lineState = curBit ? LINE_HIGHP : LINE_HIGHN;
      S_WAKE, S_EXIT: lineState = LINE_HIGHP;
      default: lineState = LINE_SPACE;
    endcase
  end

  assign busy       = (state != S_STOP);
  assign ulpsActive = (state == S_ULPS);
  assign txReady    = (state == S_WAIT);
  assign rstTrigger = (state == S_EXIT) && timerDone && (modeReg == MODE_RESET);

  assert_entry_opens_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP && start && modeIn != MODE_RSVD) |=> (lineState == LINE_HIGHP));

  assert_reserved_mode_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP && start && modeIn == MODE_RSVD) |=> (lineState == LINE_STOP && !busy));

  assert_busy_never_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (lineState != LINE_STOP));

  assert_byte_taken_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && txValid) |=> (!txReady && lineState != LINE_SPACE));

  assert_ulps_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ulpsActive && !wakeReq) |=> (ulpsActive && lineState == LINE_SPACE));

  assert_trigger_then_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstTrigger |=> (lineState == LINE_STOP));

endmodule

// File: rtl/lpEscTx.sv
`timescale 1ns/1ps
module lpEscTx
  import lpEscPkg::*;
#(
  parameter int LPX_CYCLES = 4,
  parameter int WAKE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [7:0]        txData,
  input  logic              txValid,
  input  logic              txLast,
  output logic              txReady,
  input  logic              wakeReq,
  input  logic [WAKE_W-1:0] wakeTime,
  output logic              lineP,
  output logic              lineN,
  output logic              busy,
  output logic              ulpsActive,
  output logic              rstTrigger
);
  dpCtrl_t    ctl;
  escMode_t   modeIn;
  logic       timerDone;
  logic       curBit;
  logic       lastBit;
  logic [1:0] lineState;

  assign modeIn = escMode_t'(mode);

  lpEscCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .modeIn     (modeIn),
    .txValid    (txValid),
    .txLast     (txLast),
    .wakeReq    (wakeReq),
    .timerDone  (timerDone),
    .curBit     (curBit),
    .lastBit    (lastBit),
    .ctl        (ctl),
    .lineState  (lineState),
    .busy       (busy),
    .ulpsActive (ulpsActive),
    .txReady    (txReady),
    .rstTrigger (rstTrigger)
  );

  lpEscDatapath #(
    .LPX_CYCLES (LPX_CYCLES),
    .WAKE_W     (WAKE_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmdMode   (modeIn),
    .dataIn    (txData),
    .wakeTime  (wakeTime),
    .timerDone (timerDone),
    .curBit    (curBit),
    .lastBit   (lastBit)
  );

  assign lineP = lineState[1];
  assign lineN = lineState[0];

endmodule

// File: tb/test_lpEscTx.sv
`timescale 1ns/1ps
module test_lpEscTx;
  localparam int L  = 2;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] txData = 8'h00;
  logic txValid = 1'b0;
  logic txLast = 1'b0;
  logic txReady;
  logic wakeReq = 1'b0;
  logic [WW-1:0] wakeTime = '0;
  logic lineP, lineN, busy, ulpsActive, rstTrigger;

  int nChecks = 0;
  int nFail = 0;

  int obsVal [256];
  int obsLen [256];
  int nObs;
  int expVal [256];
  int expLen [256];
  int nExp;

  lpEscTx #(.LPX_CYCLES(L), .WAKE_W(WW)) i_lpEscTx (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .txData(txData),
    .txValid(txValid), .txLast(txLast), .txReady(txReady), .wakeReq(wakeReq),
    .wakeTime(wakeTime), .lineP(lineP), .lineN(lineN), .busy(busy),
    .ulpsActive(ulpsActive), .rstTrigger(rstTrigger)
  );

  always #4 clk = ~clk;

  // vector: {mode, byte0, byte1, nBytes, gap, wakeTime, ulpsDelay, pokeStart}
  localparam int NV = 8;
  localparam logic [32:0] VECS [NV] = '{
    {2'd0, 8'hA5, 8'h00, 2'd1, 4'd0, 4'd0,  4'd0, 1'b0},
    {2'd0, 8'h00, 8'hFF, 2'd2, 4'd3, 4'd0,  4'd0, 1'b0},
    {2'd0, 8'h3C, 8'h81, 2'd2, 4'd9, 4'd0,  4'd0, 1'b0},
    {2'd1, 8'h00, 8'h00, 2'd0, 4'd0, 4'd5,  4'd0, 1'b0},
    {2'd1, 8'h00, 8'h00, 2'd0, 4'd0, 4'd0,  4'd6, 1'b0},
    {2'd1, 8'h00, 8'h00, 2'd0, 4'd0, 4'd15, 4'd2, 1'b0},
    {2'd2, 8'h00, 8'h00, 2'd0, 4'd0, 4'd0,  4'd0, 1'b0},
    {2'd0, 8'h5A, 8'h00, 2'd1, 4'd1, 4'd0,  4'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushObs(input int v);
    if (nObs > 0 && obsVal[nObs-1] == v) obsLen[nObs-1]++;
    else if (nObs < 256) begin obsVal[nObs] = v; obsLen[nObs] = 1; nObs++; end
  endtask

  task automatic pushExp(input int v, input int len);
    if (nExp > 0 && expVal[nExp-1] == v) expLen[nExp-1] += len;
    else if (nExp < 256) begin expVal[nExp] = v; expLen[nExp] = len; nExp++; end
  endtask

  // R5: bit 1 -> LP-10 (2), bit 0 -> LP-01 (1), then LP-00 (0)
  task automatic expByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      pushExp(b[i] ? 2 : 1, L);
      pushExp(0, L);
    end
  endtask

  task automatic runTxn(input logic [1:0] m, input logic [7:0] b0, input logic [7:0] b1,
                        input int nB, input int gap, input int wk, input int dly, input bit poke);
    int idx = 0;
    int waitCnt = 0;
    int ulpCnt = 0;
    int trig = 0;
    int accepted = 0;
    int notBusy = 0;
    int ulpsSeen = 0;
    int n = 0;
    int bad = 0;
    int firstBad = 0;
    bit done = 1'b0;
    logic [7:0] code;
    string tag;
    nObs = 0;
    nExp = 0;
    @(negedge clk);
    start = 1'b1; mode = m; wakeTime = WW'(wk);
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 4000) begin
      if ({lineP, lineN} == 2'b11) done = 1'b1;
      else begin
        pushObs(int'({lineP, lineN}));
        n++;
        if (!busy) notBusy++;
        if (rstTrigger) trig++;
        if (ulpsActive) ulpsSeen++;
        if (poke) start = (n == 6);
        if (txReady) begin
          if (waitCnt == gap && idx < nB) begin
            txValid = 1'b1;
            txData  = (idx == 0) ? b0 : b1;
            txLast  = (idx == nB - 1);
            idx++;
            accepted++;
          end else waitCnt++;
        end else begin
          txValid = 1'b0;
          waitCnt = 0;
        end
        if (ulpsActive) begin
          if (ulpCnt == dly) wakeReq = 1'b1;
          else ulpCnt++;
        end else wakeReq = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0; txValid = 1'b0; wakeReq = 1'b0;

    // expected run list from the requirements
    code = (m == 2'd0) ? 8'h87 : (m == 2'd1) ? 8'h78 : 8'h46;
    pushExp(2, L); pushExp(0, L); pushExp(1, L); pushExp(0, L);
    expByte(code);
    if (m == 2'd0) begin
      for (int i = 0; i < nB; i++) begin
        pushExp(0, gap + 1);
        expByte((i == 0) ? b0 : b1);
      end
      pushExp(2, L);
      tag = "R6";
    end else if (m == 2'd1) begin
      pushExp(0, dly + 1);
      pushExp(2, (wk == 0) ? 1 : wk);
      tag = "R8";
    end else begin
      pushExp(2, L);
      tag = "R10";
    end

    chk(done, "R11", "returned to stop", int'(done), 1);
    chk(nObs == nExp, tag, "number of line runs", nObs, nExp);
    // R2 ladder runs
    bad = 0;
    for (int i = 0; i < 4; i++)
      if (i >= nObs || obsVal[i] != expVal[i] || obsLen[i] != expLen[i]) bad++;
    chk(bad == 0, "R2", "entry ladder run mismatches", bad, 0);
    // R4 and R5 command runs
    bad = 0;
    for (int i = 4; i < 19; i++)
      if (i >= nObs || obsVal[i] != expVal[i] || obsLen[i] != expLen[i]) bad++;
    chk(bad == 0, "R4", "command bit run mismatches (R5 encoding)", bad, 0);
    // remaining runs
    bad = 0; firstBad = -1;
    for (int i = 19; i < nExp; i++)
      if (i >= nObs || obsVal[i] != expVal[i] || obsLen[i] != expLen[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    chk(bad == 0, tag, "payload or parked run mismatches", bad, 0);
    // closing LP-10 run
    if (nObs == nExp && nExp > 0)
      chk(obsLen[nObs-1] == expLen[nExp-1] && obsVal[nObs-1] == 2,
          (m == 2'd0) ? "R7" : (m == 2'd1) ? "R9" : "R10",
          "final LP-10 length", obsLen[nObs-1], expLen[nExp-1]);
    chk(notBusy == 0, "R11", "samples with busy low mid-sequence", notBusy, 0);
    chk(trig == ((m == 2'd2) ? 1 : 0), "R10", "rstTrigger pulse count", trig, (m == 2'd2) ? 1 : 0);
    chk(accepted == ((m == 2'd0) ? nB : 0), "R6", "bytes accepted", accepted, (m == 2'd0) ? nB : 0);
    chk(ulpsSeen == ((m == 2'd1) ? dly + 1 : 0), "R8", "cycles with ulpsActive", ulpsSeen,
        (m == 2'd1) ? dly + 1 : 0);
    chk(!busy && !ulpsActive && !txReady, "R11", "idle flags after stop",
        int'({busy, ulpsActive, txReady}), 0);
    if (poke) chk(nObs == nExp && bad == 0, "R3", "start during transfer left it unchanged", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int cnt;
    // R1 while reset held and after release
    repeat (3) @(negedge clk);
    chk({lineP, lineN} == 2'b11, "R1", "line in reset", int'({lineP, lineN}), 3);
    rstN = 1'b1;
    @(negedge clk);
    chk({lineP, lineN} == 2'b11 && !busy && !ulpsActive && !txReady && !rstTrigger, "R1",
        "state after reset", int'({lineP, lineN, busy, ulpsActive, txReady, rstTrigger}), 6'b110000);

    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      e = VECS[v];
      runTxn(e[32:31], e[30:23], e[22:15], int'(e[14:13]), int'(e[12:9]),
             int'(e[8:5]), int'(e[4:1]), e[0]);
      repeat (2) @(negedge clk);
    end

    // R3 reserved mode is ignored
    start = 1'b1; mode = 2'd3;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      if ({lineP, lineN} != 2'b11 || busy) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R3", "cycles off stop after reserved mode", cnt, 0);

    // R1 reset while parked
    start = 1'b1; mode = 2'd1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!ulpsActive && cnt < 200) begin cnt++; @(negedge clk); end
    chk(ulpsActive, "R8", "parked state reached", int'(ulpsActive), 1);
    rstN = 1'b0;
    #1;
    chk({lineP, lineN} == 2'b11 && !ulpsActive && !busy, "R1", "reset during parked state",
        int'({lineP, lineN, ulpsActive, busy}), 4'b1100);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    runTxn(2'd2, 8'h00, 8'h00, 0, 0, 0, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule